// File: doc/BRIEF.md
# Board Glue Register Bank with Interrupt Combiner

This block is the byte-wide register bank of a daughter board's glue logic. A host reaches it over a simple synchronous bus with an address, write data, read data, a write strobe and a read strobe. The bank holds five registers:

- a fixed identity byte;
- a read-only view of three interrupt sources;
- a general control byte;
- a writable register that drives the handshake outputs of two serial ports;
- a read-only register that shows the modem status lines of those ports.

Three peripheral interrupt requests reach the block: two are active-low levels and one is an active-high level. Each passes through a two-flop synchroniser. The block then normalises their polarity and ORs them into one registered upstream interrupt line, which the host samples on its rising edge. There is no per-source mask. Software reads the raw reason bits and must silence the sources at the upstream line. A level source stays pending until the peripheral itself releases it.

The handshake outputs are active-low and follow their register bits directly: a 0 bit asserts the line. The status inputs are also active-low and are shown unchanged after synchronisation, so a bit reads 1 while its line is inactive.

Top module: `board_glue_regs`

## Requirements
- R1: A read of offset 0x00 returns the identity value 0x11.
- R2: A read of offset 0x04 returns the synchronised raw source levels: bit 0 is the Ethernet request (0 = requesting), bit 1 is the USB/serial request (0 = requesting), bit 2 is the companion-chip request (1 = requesting), and bits 7:3 read 0.
- R3: `irq_up` is a registered output. It is low after reset. Within four clock edges of an input change, it goes high when any source is requesting after polarity normalisation, and it goes low when none is.
- R4: The sources are level-sensitive. A held request stays visible in the reason register across repeated reads and keeps `irq_up` high. The bit clears only when the source input is released.
- R5: Offset 0xb0 is read/write in bits 3:0 (bit 0 RTS1, bit 1 DTR1, bit 2 RTS2, bit 3 DTR2), and bits 7:4 read 0. It resets to 0xF. `ser_ctl_n[3:0]` outputs these bits directly, so a line is asserted when its bit is 0.
- R6: Offset 0xb4 is read-only. Bits 5:0 show the synchronised `ser_sts_n` inputs (bit 0 CTS1, bit 1 DSR1, bit 2 DCD1, bit 3 CTS2, bit 4 DSR2, bit 5 DCD2), each 1 when its line is inactive. Bits 7:6 read 0.
- R7: Offset 0x08 is an 8-bit read/write control register that resets to 0x00 and reads back what was written. It appears on `ctrl_q`. Bit 0 set to 1 turns off the drivers of the two general-purpose lines, so at reset those drivers stay enabled.
- R8: Reads of unused offsets return 0x00. Writes to read-only or unused offsets change no register and no output.
- R9: `bus_rdata` updates on the clock edge at which `bus_re` is high and holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| src_eth_n | input | 1 | Ethernet request, active-low level |
| src_usb_n | input | 1 | USB/serial request, active-low level |
| src_comp | input | 1 | Companion-chip request, active-high level |
| ser_sts_n | input | 6 | Modem status lines, active-low |
| ser_ctl_n | output | 4 | Modem handshake lines, active-low |
| ctrl_q | output | 8 | Control register contents |
| irq_up | output | 1 | Combined upstream interrupt |

## Verification
The hardest case to reach from the ports is a mix of polarities. One active-low source requests while the active-high source is idle, and then the reverse. This shows that every source is normalised on its own and that no shared inversion is applied. The bench drives each source alone and then in overlapping pairs, waiting out the synchroniser and output register before each check. It then holds one request through repeated reads of the reason register to show that reading does not clear a level source. Writes aimed at the identity, reason, status and unused offsets are followed by read-back of every writable register, which confirms that those writes were ignored.

// File: rtl/glue_pkg.sv
package glue_pkg;
  localparam logic [7:0] OFS_ID    = 8'h00;
  localparam logic [7:0] OFS_IRR   = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;
  localparam logic [7:0] OFS_MCTL0 = 8'hb0;
  localparam logic [7:0] OFS_MCTL1 = 8'hb4;
  localparam logic [7:0] ID_CONST  = 8'h11;
endpackage

// File: rtl/glue_sync.sv
module glue_sync #(
  parameter int W = 9,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[0] <= RST_VAL;
        else     pipe[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[s] <= RST_VAL;
        else     pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/glue_irq.sv
module glue_irq (
  input  logic clk,
  input  logic rst,
  input  logic eth_n_s,
  input  logic usb_n_s,
  input  logic comp_s,
  output logic irq_q
);
  logic any_req;
  assign any_req = ~eth_n_s | ~usb_n_s | comp_s;

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_req;
  end
endmodule

// File: rtl/glue_regfile.sv
module glue_regfile
  import glue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int NSRC   = 3,
  parameter int MCTL_W = 4,
  parameter int STS_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   src_raw,
  input  logic [STS_W-1:0]  sts_s,
  output logic [MCTL_W-1:0] mctl0_q,
  output logic [DATA_W-1:0] ctrl_reg
);
  localparam logic [MCTL_W-1:0] MCTL_RST = '1;

  logic hit_id, hit_irr, hit_ctrl, hit_mc0, hit_mc1;
  assign hit_id   = (addr == ADDR_W'(OFS_ID));
  assign hit_irr  = (addr == ADDR_W'(OFS_IRR));
  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_mc0  = (addr == ADDR_W'(OFS_MCTL0));
  assign hit_mc1  = (addr == ADDR_W'(OFS_MCTL1));

  always_ff @(posedge clk) begin
    if (rst) begin
      mctl0_q  <= MCTL_RST;
      ctrl_reg <= '0;
    end else if (we) begin
      if (hit_mc0)  mctl0_q  <= wdata[MCTL_W-1:0];
      if (hit_ctrl) ctrl_reg <= wdata;
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_id)   rd_mux = DATA_W'(ID_CONST);
    if (hit_irr)  rd_mux[NSRC-1:0]   = src_raw;
    if (hit_ctrl) rd_mux = ctrl_reg;
    if (hit_mc0)  rd_mux[MCTL_W-1:0] = mctl0_q;
    if (hit_mc1)  rd_mux[STS_W-1:0]  = sts_s;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= rd_mux;
  end
endmodule

// File: rtl/board_glue_regs.sv
module board_glue_regs #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 8,
  parameter int MCTL_W      = 4,
  parameter int STS_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              src_eth_n,
  input  logic              src_usb_n,
  input  logic              src_comp,
  input  logic [STS_W-1:0]  ser_sts_n,
  output logic [MCTL_W-1:0] ser_ctl_n,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              irq_up
);
  localparam int NSRC = 3;
  localparam int SW   = NSRC + STS_W;
  localparam logic [SW-1:0] IDLE = {{STS_W{1'b1}}, 1'b0, 1'b1, 1'b1};

  logic [SW-1:0] async_in, sync_out;
  assign async_in = {ser_sts_n, src_comp, src_usb_n, src_eth_n};

  glue_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(async_in), .q(sync_out)
  );

  glue_irq u_irq (
    .clk(clk), .rst(rst),
    .eth_n_s(sync_out[0]), .usb_n_s(sync_out[1]), .comp_s(sync_out[2]),
    .irq_q(irq_up)
  );

  glue_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSRC(NSRC),
    .MCTL_W(MCTL_W), .STS_W(STS_W)
  ) u_regs (
    .clk(clk), .rst(rst),
    .addr(bus_addr), .wdata(bus_wdata), .we(bus_we), .re(bus_re),
    .rdata(bus_rdata),
    .src_raw(sync_out[NSRC-1:0]),
    .sts_s(sync_out[SW-1:NSRC]),
    .mctl0_q(ser_ctl_n),
    .ctrl_reg(ctrl_q)
  );
endmodule

// File: rtl/glue_chk.sv
module glue_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int MCTL_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [MCTL_W-1:0] ser_ctl_n,
  input logic [DATA_W-1:0] ctrl_q
);
  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(8'h00)) || (bus_addr == ADDR_W'(8'h04)) ||
                  (bus_addr == ADDR_W'(8'h08)) || (bus_addr == ADDR_W'(8'hb0)) ||
                  (bus_addr == ADDR_W'(8'hb4));

  AST_ID_VALUE: assert property (@(posedge clk) disable iff (rst)
    bus_re && bus_addr == ADDR_W'(8'h00) |=> bus_rdata == DATA_W'(8'h11)); // R1
  AST_MCTL0_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADDR_W'(8'hb0)) |=> $stable(ser_ctl_n)); // R5
  AST_MCTL1_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_re && bus_addr == ADDR_W'(8'hb4) |=> bus_rdata[7:6] == 2'b00); // R6
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == ADDR_W'(8'h08)) |=> $stable(ctrl_q)); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    bus_re && !mapped |=> bus_rdata == '0); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata)); // R9
endmodule

bind board_glue_regs glue_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MCTL_W(MCTL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .ser_ctl_n(ser_ctl_n), .ctrl_q(ctrl_q)
);

// File: tb/sim_board_glue_regs.sv
`timescale 1ns/1ps
module sim_board_glue_regs;
  logic clk = 0, rst = 1;
  logic [7:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic bus_we = 0, bus_re = 0;
  logic src_eth_n = 1, src_usb_n = 1, src_comp = 0;
  logic [5:0] ser_sts_n = 6'h3F;
  logic [3:0] ser_ctl_n;
  logic [7:0] ctrl_q;
  logic irq_up;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  board_glue_regs u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1;
    @(negedge clk); bus_re = 0; d = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check(irq_up == 0, "R3 irq low after reset", irq_up, 0);
    check(ser_ctl_n == 4'hF, "R5 handshake reset", ser_ctl_n, 4'hF);
    check(ctrl_q == 8'h00, "R7 ctrl reset", ctrl_q, 0);
    rd(8'hb0, d); check(d == 8'h0F, "R5 mctl0 read reset", d, 8'h0F);
  endtask

  task automatic t_id();
    logic [7:0] d;
    rd(8'h00, d); check(d == 8'h11, "R1 identity", d, 8'h11);
  endtask

  task automatic t_sources();
    logic [7:0] d;
    rd(8'h04, d); check(d == 8'h03, "R2 idle reason", d, 8'h03);
    src_eth_n = 0; settle();
    check(irq_up == 1, "R3 eth only", irq_up, 1);
    rd(8'h04, d); check(d == 8'h02, "R2 eth pending", d, 8'h02);
    src_eth_n = 1; settle();
    check(irq_up == 0, "R3 eth released", irq_up, 0);
    src_usb_n = 0; settle();
    check(irq_up == 1, "R3 usb only", irq_up, 1);
    rd(8'h04, d); check(d == 8'h01, "R2 usb pending", d, 8'h01);
    src_usb_n = 1; src_comp = 1; settle();
    check(irq_up == 1, "R3 companion only", irq_up, 1);
    rd(8'h04, d); check(d == 8'h07, "R2 companion pending", d, 8'h07);
    src_eth_n = 0; settle();
    rd(8'h04, d); check(d == 8'h06, "R2 eth+companion", d, 8'h06);
    src_eth_n = 1; src_comp = 0; settle();
    check(irq_up == 0, "R3 all idle", irq_up, 0);
  endtask

  task automatic t_level();
    logic [7:0] d;
    src_usb_n = 0; settle();
    for (int i = 0; i < 3; i++) begin
      rd(8'h04, d); check(d[1] == 0, "R4 usb stays pending", d, 8'h01);
      check(irq_up == 1, "R4 irq held", irq_up, 1);
    end
    src_usb_n = 1; settle();
    rd(8'h04, d); check(d[1] == 1, "R4 usb cleared by source", d, 8'h03);
    check(irq_up == 0, "R4 irq released", irq_up, 0);
  endtask

  task automatic t_mctl();
    logic [7:0] d;
    wr(8'hb0, 8'hFA);
    check(ser_ctl_n == 4'hA, "R5 RTS1/RTS2 asserted", ser_ctl_n, 4'hA);
    rd(8'hb0, d); check(d == 8'h0A, "R5 mctl0 readback", d, 8'h0A);
    wr(8'hb0, 8'h05);
    check(ser_ctl_n == 4'h5, "R5 DTR1/DTR2 asserted", ser_ctl_n, 4'h5);
    ser_sts_n = 6'h2A; settle();
    rd(8'hb4, d); check(d == 8'h2A, "R6 status pattern A", d, 8'h2A);
    ser_sts_n = 6'h15; settle();
    rd(8'hb4, d); check(d == 8'h15, "R6 status pattern B", d, 8'h15);
    ser_sts_n = 6'h3F;
  endtask

  task automatic t_ctrl();
    logic [7:0] d;
    wr(8'h08, 8'h01);
    check(ctrl_q == 8'h01, "R7 gp drivers off", ctrl_q, 8'h01);
    rd(8'h08, d); d = d | 8'hC0; wr(8'h08, d);
    rd(8'h08, d); check(d == 8'hC1, "R7 read-modify-write", d, 8'hC1);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    wr(8'h00, 8'hFF); wr(8'h04, 8'hFF); wr(8'hb4, 8'hFF); wr(8'h40, 8'hFF);
    rd(8'h00, d); check(d == 8'h11, "R8 id unwritable", d, 8'h11);
    rd(8'h04, d); check(d == 8'h03, "R8 reason unwritable", d, 8'h03);
    rd(8'hb4, d); check(d == 8'h3F, "R8 status unwritable", d, 8'h3F);
    check(ctrl_q == 8'hC1, "R8 ctrl untouched", ctrl_q, 8'hC1);
    check(ser_ctl_n == 4'h5, "R8 handshake untouched", ser_ctl_n, 4'h5);
    rd(8'h40, d); check(d == 8'h00, "R8 unused reads zero", d, 0);
    rd(8'hb8, d); check(d == 8'h00, "R8 unused b8 zero", d, 0);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    rd(8'h00, d);
    @(negedge clk); bus_addr = 8'h40;
    repeat (3) @(negedge clk);
    check(bus_rdata == 8'h11, "R9 rdata held without strobe", bus_rdata, 8'h11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset(); t_id(); t_sources(); t_level(); t_mctl(); t_ctrl(); t_unused(); t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule